// File: doc/BRIEF.md
# Write-Only I2C Command Master

This block is an I2C bus master that only writes. Upstream logic hands it 32-bit command words over a valid/ready stream. Each word asks for one of three things: a stop condition, a start condition followed by data bytes, or data bytes alone. The block turns the word into a fixed run of bus phases. It drives SCL and SDA as open-drain pull-down enables: a 1 on an output pulls that line low, and a 0 releases it to the pull-up.

Bus timing comes from an internal tick that fires once every `clk_div + 1` system clocks. One bus bit lasts 32 ticks, so `clk_div` is chosen so that 32 ticks equal one period of the target bus rate, such as 100 kHz or 400 kHz.

The block never reads the bus. It has no acknowledge check, no clock stretching and no arbitration. The stream interface applies back-pressure in a simple way: `in_ready` is high only while the block is idle, and a word moves across only on a clock edge where `in_valid` and `in_ready` are both high. The producer has to keep a word waiting until that edge. To keep bytes flowing back to back within one bus transaction, it should have the next word ready as soon as `in_ready` rises.

Top module: `i2cw_master`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `in_ready` is 1, and both `scl_low` and `sda_low` are 0. The lines are released whenever the block is idle.
- R2: A word is taken only on a clock edge with `in_valid` and `in_ready` both high, and `busy` is 1 on the next cycle. A valid word offered while `busy` is 1 is not taken and has no effect on the bus.
- R3: Bit 25 is the STOP flag and takes priority. A word with bit 25 set runs only the stop sequence, whatever bit 24 and the other fields hold.
- R4: Bit 24 is the START flag. When it is set and STOP is clear, the block first runs three 8-tick phases and then sends the data bytes: (SCL released, SDA released), then (SCL released, SDA low), then (both low).
- R5: Each data bit lasts 32 ticks, in four 8-tick phases: SCL low, SCL released, SCL released, SCL low. SDA holds the bit for all four phases, with a 1 bit releasing SDA and a 0 bit pulling it low. Bits go out MSB first.
- R6: Bits 27..26 hold the byte count minus one, so 0, 1 and 2 send 1, 2 and 3 bytes. The value 3 also sends 3 bytes. Bytes are sent from bits 23..16, then 15..8, then 7..0.
- R7: After each byte comes a 27-tick acknowledge slot with SDA released throughout: SCL low for 8 ticks, SCL released for 8 ticks, then SCL low for 11 ticks. SDA is never sampled.
- R8: The stop sequence is both lines low for 8 ticks, then SCL released with SDA low for 8 ticks. After that the block goes idle with both lines released.
- R9: A tick fires once every `clk_div + 1` system clocks while busy, so an 8-tick phase lasts `8*(clk_div+1)` clocks.
- R10: `busy` is 1 from the cycle after a word is taken until the last phase of that word ends, and `in_ready` is 0 for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Tick period minus one, counted in system clocks |
| in_valid | input | 1 | A command word is offered |
| in_ready | output | 1 | The block is idle and will take a word |
| in_data | input | 32 | Command word |
| busy | output | 1 | A command is in progress |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle that the lines are released while idle, that a handshake always makes the block busy, that SDA changes while SCL is released only for the start edge or the final stop release, and that ticks never fire on back-to-back clocks when the divider is above zero. Exact phase lengths, MSB-first bit order, byte selection by the count field, the priority of STOP over START and the ignoring of words offered while busy can only be seen in the bench scenarios. Each scenario compares every clock of the line waveform against a sequence that the bench builds from the command word.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int WORD_W      = 32;
  localparam int PAYLOAD_W   = 24;
  localparam int PHASE_TICKS = 8;
  localparam int ACK_EXTRA   = 3;
  localparam int TCNT_W      = $clog2(PHASE_TICKS + ACK_EXTRA + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP
  } seq_state_e;

  typedef struct packed {
    logic                 stop;
    logic                 start;
    logic [1:0]           extra_bytes;
    logic [PAYLOAD_W-1:0] payload;
  } cmd_t;
endpackage

// File: rtl/i2cw_cmd_decode.sv
module i2cw_cmd_decode
  import i2cw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  always_comb begin
    cmd.stop        = word[25];
    cmd.start       = word[24];
    // a count field of 3 is clamped to three bytes
    cmd.extra_bytes = (word[27:26] == 2'd3) ? 2'd2 : word[27:26];
    cmd.payload     = word[PAYLOAD_W-1:0];
  end
endmodule

// File: rtl/i2cw_tick_gen.sv
module i2cw_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cw_line_map.sv
module i2cw_line_map
  import i2cw_pkg::*;
(
  input  seq_state_e st,
  input  logic [1:0] ph,
  input  logic       bit_val,
  output logic       scl_low,
  output logic       sda_low
);
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (st)
      ST_START: begin
        scl_low = (ph == 2'd2);
        sda_low = (ph != 2'd0);
      end
      ST_BIT: begin
        scl_low = (ph == 2'd0) || (ph == 2'd3);
        sda_low = !bit_val;
      end
      ST_ACK: begin
        scl_low = (ph != 2'd1);
        sda_low = 1'b0;
      end
      ST_STOP: begin
        scl_low = (ph == 2'd0);
        sda_low = 1'b1;
      end
      default: begin
        scl_low = 1'b0;
        sda_low = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
  import i2cw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              busy,
  output logic              scl_low,
  output logic              sda_low
);
  localparam logic [TCNT_W-1:0] LEN_STD = TCNT_W'(PHASE_TICKS - 1);
  localparam logic [TCNT_W-1:0] LEN_ACK = TCNT_W'(PHASE_TICKS + ACK_EXTRA - 1);

  cmd_t                 cmd_d;
  seq_state_e           st;
  logic [1:0]           ph;
  logic [TCNT_W-1:0]    tcnt;
  logic [2:0]           bidx;
  logic [1:0]           left;
  logic [PAYLOAD_W-1:0] sh;
  logic                 tick_w;
  logic                 accept;
  logic [TCNT_W-1:0]    last_cnt;
  logic                 ph_end;

  assign busy     = (st != ST_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign last_cnt = (st == ST_ACK && ph == 2'd2) ? LEN_ACK : LEN_STD;
  assign ph_end   = tick_w && (tcnt == last_cnt);

  i2cw_cmd_decode u_dec (
    .word (in_data),
    .cmd  (cmd_d)
  );

  i2cw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (clk_div),
    .tick (tick_w)
  );

  i2cw_line_map u_map (
    .st     (st),
    .ph     (ph),
    .bit_val(sh[PAYLOAD_W-1]),
    .scl_low(scl_low),
    .sda_low(sda_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ph   <= '0;
      tcnt <= '0;
      bidx <= '0;
      left <= '0;
      sh   <= '0;
    end else if (accept) begin
      ph   <= '0;
      tcnt <= '0;
      bidx <= 3'd7;
      left <= cmd_d.extra_bytes;
      sh   <= cmd_d.payload;
      if (cmd_d.stop)       st <= ST_STOP;
      else if (cmd_d.start) st <= ST_START;
      else                  st <= ST_BIT;
    end else if (tick_w) begin
      if (!ph_end) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (st)
          ST_START: begin
            if (ph == 2'd2) begin
              st   <= ST_BIT;
              ph   <= '0;
              bidx <= 3'd7;
            end else ph <= ph + 1'b1;
          end
          ST_BIT: begin
            if (ph == 2'd3) begin
              ph <= '0;
              sh <= {sh[PAYLOAD_W-2:0], 1'b0};
              if (bidx == 3'd0) st <= ST_ACK;
              else              bidx <= bidx - 1'b1;
            end else ph <= ph + 1'b1;
          end
          ST_ACK: begin
            if (ph == 2'd2) begin
              ph <= '0;
              if (left == 2'd0) st <= ST_IDLE;
              else begin
                left <= left - 1'b1;
                bidx <= 3'd7;
                st   <= ST_BIT;
              end
            end else ph <= ph + 1'b1;
          end
          ST_STOP: begin
            if (ph == 2'd1) begin
              ph <= '0;
              st <= ST_IDLE;
            end else ph <= ph + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             scl_low,
  input logic             sda_low,
  input logic             tick,
  input logic [DIV_W-1:0] clk_div
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R4 / R8: SDA may move under a released SCL only for start or final stop release
  p_sda_under_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && !$stable(sda_low)) |->
      (($rose(sda_low) && busy) || ($fell(sda_low) && !busy)));

  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_div != '0) |=> !tick);
endmodule

bind i2cw_master i2cw_checker #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .busy    (busy),
  .scl_low (scl_low),
  .sda_low (sda_low),
  .tick    (tick_w),
  .clk_div (clk_div)
);

// File: tb/sim_i2cw_master.sv
module sim_i2cw_master;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_data = '0;
  logic             busy;
  logic             scl_low;
  logic             sda_low;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [1:0] exp_q[$];

  always #10 clk = ~clk;

  i2cw_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .busy(busy),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit scl, input bit sda, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({scl, sda});
  endtask

  // expected per-tick line pulls {scl_low, sda_low}, built from the word format
  task automatic build(input logic [31:0] w);
    int nb;
    exp_q.delete();
    nb = (w[27:26] == 2'd3) ? 3 : int'(w[27:26]) + 1;
    if (w[25]) begin
      push(1, 1, 8); push(0, 1, 8);
    end else begin
      if (w[24]) begin
        push(0, 0, 8); push(0, 1, 8); push(1, 1, 8);
      end
      for (int b = 0; b < nb; b++) begin
        logic [7:0] by;
        by = w[23 - 8*b -: 8];
        for (int k = 7; k >= 0; k--) begin
          bit p;
          p = !by[k];
          push(1, p, 8); push(0, p, 8); push(0, p, 8); push(1, p, 8);
        end
        push(1, 0, 8); push(0, 0, 8); push(1, 0, 11);
      end
    end
  endtask

  task automatic run_cmd(input logic [31:0] w, input string req, input bit noise);
    int bad_cyc = -1;
    logic [1:0] bad_act = '0, bad_exp = '0;
    bit busy_ok = 1;
    int cyc = 0;
    build(w);
    @(negedge clk);
    check(in_ready === 1'b1, req, "ready before send", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    if (noise) in_data = 32'h0100_00FF;
    else       in_valid = 1'b0;
    foreach (exp_q[i]) begin
      for (int r = 0; r <= int'(clk_div); r++) begin
        if (noise && cyc == 20) in_valid = 1'b0;
        if ({scl_low, sda_low} !== exp_q[i] && bad_cyc < 0) begin
          bad_cyc = cyc; bad_act = {scl_low, sda_low}; bad_exp = exp_q[i];
        end
        if (busy !== 1'b1 || in_ready !== 1'b0) busy_ok = 0;
        cyc++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    check(bad_cyc < 0, req, $sformatf("line waveform cycle %0d", bad_cyc),
          {30'd0, bad_act}, {30'd0, bad_exp});
    check(busy_ok, {req, " R10"}, "busy high through command", 32'd0, 32'd1);
    check(busy === 1'b0 && in_ready === 1'b1 && scl_low === 1'b0 && sda_low === 1'b0,
          {req, " R10 R1"}, "idle after command",
          {28'd0, busy, in_ready, scl_low, sda_low}, 32'b0100);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy === 1'b0 && in_ready === 1'b1 && scl_low === 1'b0 && sda_low === 1'b0,
          "R1", "reset state", {28'd0, busy, in_ready, scl_low, sda_low}, 32'b0100);
  endtask

  task automatic t_start_byte();  run_cmd(32'h0100_00A5, "R4 R5 R7", 0); endtask
  task automatic t_two_bytes();   run_cmd(32'h0400_3C81, "R5 R6", 0); endtask
  task automatic t_three_bytes(); run_cmd(32'h0912_3456, "R4 R6", 0); endtask
  task automatic t_count_clamp(); run_cmd(32'h0CF0_0FAA, "R6", 0); endtask
  task automatic t_stop_prio();   run_cmd(32'h0BFF_FFFF, "R3 R8", 0); endtask
  task automatic t_stop_plain();  run_cmd(32'h0200_0000, "R8", 0); endtask
  task automatic t_busy_ignore(); run_cmd(32'h0000_005A, "R2", 1); endtask

  task automatic t_divider();
    clk_div = 16'd2;
    run_cmd(32'h0100_00C3, "R9", 0);
    clk_div = 16'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_start_byte();
    t_two_bytes();
    t_three_bytes();
    t_count_clamp();
    t_stop_prio();
    t_stop_plain();
    t_busy_ignore();
    t_divider();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule